// File: doc/BRIEF.md
# Packed Double-Element Lane Shuffle Unit

This execution datapath serves a SIMD register file whose vector registers are 256 bits wide. It accepts two vector operands, the present contents of the destination register, an 8-bit select immediate and a two-bit mode code. It returns the new 256-bit destination value one clock later. Each 128-bit lane is treated as a pair of 64-bit elements. Within a lane, the lower result element is always drawn from the first operand and the upper result element is always drawn from the second operand. One immediate bit decides, for each result element, whether the lower or the upper element of its operand is taken.

Three modes are supported. In the legacy narrow mode the first operand is the old destination, and the upper half of the register keeps its old contents. In the encoded narrow mode the upper half is cleared. In the encoded wide mode the upper lane is shuffled with two further immediate bits. Elements pass through bit-for-bit, so NaN and denormal patterns leave unchanged and no arithmetic flags exist. A valid/ready handshake at the input and a registered valid/ready output hold every result until the consumer accepts it. Flags mark reserved immediate bits and an illegal mode code.

Top module: `vshuf_pd_unit`

## Requirements
- R1: Result bits [63:0] equal operand A bits [63:0] when imm[0] is 0, and operand A bits [127:64] when imm[0] is 1.
- R2: Result bits [127:64] equal operand B bits [63:0] when imm[1] is 0, and operand B bits [127:64] when imm[1] is 1.
- R3: In wide mode (mode 2'b10), result bits [191:128] equal A bits [191:128] when imm[2] is 0 and A bits [255:192] when it is 1. Result bits [255:192] equal B bits [191:128] when imm[3] is 0 and B bits [255:192] when it is 1.
- R4: In legacy narrow mode (mode 2'b00), the first operand is the old destination input `old_dst`; `src_a` is ignored. Result bits [255:128] equal `old_dst` bits [255:128].
- R5: In encoded narrow mode (mode 2'b01), result bits [255:128] are zero.
- R6: `rsvd_flag` is 1 alongside a result when any reserved immediate bit was set: bits [7:2] in the narrow modes, bits [7:4] in wide mode. Reserved bits never change the result.
- R7: Mode 2'b11 gives an all-zero result with `bad_mode` set to 1. `bad_mode` is 0 for every other mode.
- R8: `out_valid` rises in the cycle after an input transfer (`in_valid` and `in_ready` both high). The result and the flags hold steady while `out_valid` is high and `out_ready` is low.
- R9: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low.
- R10: A synchronous active-high reset clears `out_valid`, `rsvd_flag` and `bad_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| mode | input | 2 | 00 legacy narrow, 01 encoded narrow, 10 wide, 11 illegal |
| imm | input | 8 | Select immediate |
| old_dst | input | 256 | Current destination register contents |
| src_a | input | 256 | First operand (encoded modes) |
| src_b | input | 256 | Second operand |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| result | output | 256 | New destination value |
| rsvd_flag | output | 1 | A reserved immediate bit was set |
| bad_mode | output | 1 | The mode code was illegal |

## Verification
Every result, together with both flags, appears in the cycle after its input transfer. It then stays unchanged until a cycle in which `out_ready` is high. The bench keeps a queue of expected outputs and fills it from its own model at each accepted transfer. When `out_valid` and `out_ready` are both high, it removes the oldest entry and compares it with the outputs. The bench samples on the falling edge, half a period after the registering edge. It also checks `in_ready` against the present output state in every cycle.

// File: rtl/vshuf_pkg.sv
package vshuf_pkg;
  localparam int ELEM_W = 64;
  localparam int LANE_W = 2 * ELEM_W;
  localparam int VEC_W  = 2 * LANE_W;
  localparam int IMM_W  = 8;

  typedef enum logic [1:0] {
    MODE_LEG128 = 2'b00,
    MODE_ENC128 = 2'b01,
    MODE_ENC256 = 2'b10,
    MODE_BAD    = 2'b11
  } shuf_mode_e;

  typedef struct packed {
    logic [VEC_W-1:0] data;
    logic             rsvd;
    logic             bad;
  } shuf_res_t;
endpackage

// File: rtl/vshuf_lane.sv
module vshuf_lane #(
  parameter int EW = 64
) (
  input  logic [2*EW-1:0] a,
  input  logic [2*EW-1:0] b,
  input  logic            sel_lo,
  input  logic            sel_hi,
  output logic [2*EW-1:0] y
);
  always_comb begin
    y[EW-1:0]    = sel_lo ? a[2*EW-1:EW] : a[EW-1:0];
    y[2*EW-1:EW] = sel_hi ? b[2*EW-1:EW] : b[EW-1:0];
  end
endmodule

// File: rtl/vshuf_comb.sv
module vshuf_comb
  import vshuf_pkg::*;
#(
  parameter int EW    = ELEM_W,
  parameter int LANES = 2
) (
  input  shuf_mode_e          mode,
  input  logic [IMM_W-1:0]    imm,
  input  logic [LANES*2*EW-1:0] old_dst,
  input  logic [LANES*2*EW-1:0] src_a,
  input  logic [LANES*2*EW-1:0] src_b,
  output logic [LANES*2*EW-1:0] data,
  output logic                rsvd,
  output logic                bad
);
  localparam int LW = 2 * EW;
  localparam int VW = LANES * LW;

  logic [VW-1:0] first_op;
  logic [VW-1:0] shuf;

  assign first_op = (mode == MODE_LEG128) ? old_dst : src_a;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vshuf_lane #(.EW(EW)) u_lane (
      .a      (first_op[l*LW +: LW]),
      .b      (src_b[l*LW +: LW]),
      .sel_lo (imm[2*l]),
      .sel_hi (imm[2*l+1]),
      .y      (shuf[l*LW +: LW])
    );
  end

  always_comb begin
    data = '0;
    rsvd = 1'b0;
    bad  = 1'b0;
    unique case (mode)
      MODE_LEG128: begin
        data = {old_dst[VW-1:LW], shuf[LW-1:0]};
        rsvd = |imm[IMM_W-1:2];
      end
      MODE_ENC128: begin
        data = {{(VW-LW){1'b0}}, shuf[LW-1:0]};
        rsvd = |imm[IMM_W-1:2];
      end
      MODE_ENC256: begin
        data = shuf;
        rsvd = |imm[IMM_W-1:2*LANES];
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/vshuf_pd_unit.sv
module vshuf_pd_unit
  import vshuf_pkg::*;
#(
  parameter int EW = ELEM_W,
  parameter int VW = VEC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    mode,
  input  logic [7:0]    imm,
  input  logic [VW-1:0] old_dst,
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] result,
  output logic          rsvd_flag,
  output logic          bad_mode
);
  localparam int LANES = VW / (2 * EW);

  logic [VW-1:0] c_data;
  logic          c_rsvd;
  logic          c_bad;
  logic          take;

  vshuf_comb #(.EW(EW), .LANES(LANES)) u_comb (
    .mode    (shuf_mode_e'(mode)),
    .imm     (imm),
    .old_dst (old_dst),
    .src_a   (src_a),
    .src_b   (src_b),
    .data    (c_data),
    .rsvd    (c_rsvd),
    .bad     (c_bad)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (take) result <= c_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      rsvd_flag <= 1'b0;
      bad_mode  <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      rsvd_flag <= c_rsvd;
      bad_mode  <= c_bad;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      rsvd_flag <= 1'b0;
      bad_mode  <= 1'b0;
    end
  end
endmodule

// File: rtl/vshuf_pd_unit_chk.sv
module vshuf_pd_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] mode,
  input logic [7:0] imm,
  input logic [255:0] result,
  input logic       rsvd_flag,
  input logic       bad_mode
);
  a_r8_valid_after_take: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(rsvd_flag) && $stable(bad_mode)));
  a_r9_ready_rule: assert property (@(posedge clk) disable iff (rst)
    in_ready == !(out_valid && !out_ready));
  a_r7_bad_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && mode == 2'b11) |=> (bad_mode && result == '0));
  a_r7_good_mode: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && mode != 2'b11) |=> !bad_mode);
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && mode == 2'b01) |=> (result[255:128] == '0));
  a_r6_flag_wide: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && mode == 2'b10) |=> (rsvd_flag == (|$past(imm[7:4]))));
  a_r10_reset: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !rsvd_flag && !bad_mode));
endmodule

bind vshuf_pd_unit vshuf_pd_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .mode(mode), .imm(imm),
  .result(result), .rsvd_flag(rsvd_flag), .bad_mode(bad_mode)
);

// File: tb/vshuf_pd_unit_tb.sv
module vshuf_pd_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] mode = 2'b00;
  logic [7:0] imm = 8'h00;
  logic [255:0] old_dst = '0, src_a = '0, src_b = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [255:0] result;
  logic rsvd_flag, bad_mode;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [255:0] d;
    logic r;
    logic b;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  vshuf_pd_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .mode(mode), .imm(imm), .old_dst(old_dst), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .rsvd_flag(rsvd_flag), .bad_mode(bad_mode)
  );

  function automatic logic [63:0] el(logic [255:0] v, int i);
    return v[i*64 +: 64];
  endfunction

  function automatic exp_t model(logic [1:0] m, logic [7:0] k,
                                 logic [255:0] od, logic [255:0] a,
                                 logic [255:0] b, string tag);
    exp_t e;
    logic [255:0] s1;
    e.tag = tag;
    e.d = '0;
    e.r = 0;
    e.b = 0;
    s1 = (m == 2'b00) ? od : a;
    if (m == 2'b11) begin
      e.b = 1;
    end else begin
      e.d[63:0]   = k[0] ? el(s1, 1) : el(s1, 0);
      e.d[127:64] = k[1] ? el(b, 1) : el(b, 0);
      if (m == 2'b10) begin
        e.d[191:128] = k[2] ? el(s1, 3) : el(s1, 2);
        e.d[255:192] = k[3] ? el(b, 3) : el(b, 2);
        e.r = (k[7:4] != 0);
      end else begin
        if (m == 2'b00) e.d[255:128] = od[255:128];
        e.r = (k[7:2] != 0);
      end
    end
    return e;
  endfunction

  task automatic check(string what, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // Scoreboard on the falling edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R9 in_ready", {255'd0, in_ready}, {255'd0, !(out_valid && !out_ready)});
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check("R8 unexpected out_valid", 256'd1, 256'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check({e.tag, " data"}, result, e.d);
          check({e.tag, " R6 rsvd_flag"}, {255'd0, rsvd_flag}, {255'd0, e.r});
          check({e.tag, " R7 bad_mode"}, {255'd0, bad_mode}, {255'd0, e.b});
        end
      end
    end
  end

  // Record transfers at the edge where they occur (inputs are stable then).
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && in_valid && in_ready)
      q.push_back(model(mode, imm, old_dst, src_a, src_b, cur_tag));
  end

  string cur_tag = "";

  task automatic issue(logic [1:0] m, logic [7:0] k, string tag);
    @(negedge clk);
    mode = m; imm = k; cur_tag = tag;
    old_dst = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    src_a   = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    src_b   = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    in_valid = 1;
    do @(posedge clk); while (!in_ready);
    #1 in_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 out_valid after reset", {255'd0, out_valid}, 256'd0);
    check("R10 flags after reset", {254'd0, rsvd_flag, bad_mode}, 256'd0);
    rst = 0;
    for (int k = 0; k < 4; k++) issue(2'b00, 8'(k), "R1 R2 R4 legacy");
    for (int k = 0; k < 4; k++) issue(2'b01, 8'(k), "R1 R2 R5 enc128");
    for (int k = 0; k < 16; k++) issue(2'b10, 8'(k), "R3 wide");
    issue(2'b00, 8'hFC, "R6 legacy reserved");
    issue(2'b01, 8'h04, "R6 enc128 reserved");
    issue(2'b10, 8'h10, "R6 wide reserved");
    issue(2'b10, 8'hF5, "R6 wide reserved mix");
    issue(2'b11, 8'h03, "R7 illegal");
    // Back-to-back with stalls on the output.
    fork
      begin
        for (int i = 0; i < 12; i++) issue(2'(i % 3), 8'(i * 37), "R8 stall");
      end
      begin
        for (int i = 0; i < 40; i++) begin
          @(negedge clk);
          #1 out_ready = (i % 3) != 0;
        end
        out_ready = 1;
      end
    join
    // Stall the held result for a few cycles and watch it stay put.
    issue(2'b10, 8'h0A, "R8 hold");
    @(negedge clk);
    out_ready = 0;
    begin
      logic [255:0] held;
      #1 held = result;
      repeat (3) @(negedge clk);
      check("R8 result held while stalled", result, held);
      check("R8 out_valid held", {255'd0, out_valid}, 256'd1);
    end
    out_ready = 1;
    repeat (4) @(negedge clk);
    check("R8 queue drained", 256'(q.size()), 256'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule